// File: doc/BRIEF.md
# Memory Command Priority Arbiter

This block picks, every cycle, the single command that goes next to the memory interface. There are three kinds of candidate. The first is a command from the memory manager, such as a direct command or a self-refresh. The second is a pending auto-refresh for one of the external chips. The third is a valid entry of the AXI arbiter queue. Each queue entry comes with flags that say:

- whether it is a read or a write;
- whether it hits an open row;
- whether it carries a minimum-latency or maximum-latency timeout;
- whether it needs a preparation operation;
- which other queue entries it still depends on.

The grant is combinational and one-hot. A grant is taken when the memory interface raises `gnt_ready`. Only taken grants change the state. That state is the direction of the last granted entry, the read/write round-robin preference, and the per-chip counters of outstanding auto-refreshes. Each counter drives a sticky refresh-timeout flag, so that a backlog of refreshes is cleared before other work starves the memory of refresh.

Top module: `mem_cmd_arbiter`

## Requirements
- R1: `gnt` has at most one bit set. Bit 0 is the memory-manager command. Bits 1 to 4 are refresh for chips 0 to 3. Bits 5 to 12 are queue entries 0 to 7. `gnt` is all zero when no candidate exists.
- R2: A memory-manager command (`mm_valid`) is granted ahead of every other candidate.
- R3: A chip whose refresh timeout is set is granted its refresh ahead of every queue entry.
- R4: Among eligible queue entries the priority is, from highest: minimum-latency timeout, then maximum-latency timeout, then open-row hit.
- R5: An open-row hit in the same direction as the last granted entry beats one in the opposite direction. The direction encoding is `ent_write`=1 for a write. The last direction is read after reset.
- R6: Entries that need preparation rank below open-row hits and above plain (non-timed-out) refreshes.
- R7: When nothing above applies, an eligible entry is granted round-robin between reads and writes. Reads are preferred first after reset, and each taken fallback grant hands the preference to the other direction.
- R8: Ties inside one level, among entries or among chips, go to the lowest index.
- R9: An entry is not eligible while any bit of its dependency mask (`ent_dep[i*8 +: 8]`) points at a valid entry. It becomes eligible once those entries are invalid.
- R10: Each chip's refresh counter rises on `ref_inc` for that chip and falls on a taken refresh grant for that chip. Both in one cycle leave it unchanged. A refresh is only granted while its count is non-zero.
- R11: A chip's `ref_tmo` bit sets when its count reaches six. It stays set while the count is non-zero and clears when the count returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mm_valid | input | 1 | Memory-manager command pending |
| ent_valid | input | 8 | Queue entry valid |
| ent_write | input | 8 | Entry direction, 1 = write |
| ent_hit | input | 8 | Entry hits an open row |
| ent_tmin | input | 8 | Entry has a minimum-latency timeout |
| ent_tmax | input | 8 | Entry has a maximum-latency timeout |
| ent_prep | input | 8 | Entry needs a preparation operation |
| ent_dep | input | 64 | Dependency mask per entry, entry i at bits [i*8 +: 8] |
| ref_inc | input | 1 | New auto-refresh request |
| ref_inc_chip | input | 2 | Chip of the new auto-refresh |
| gnt_ready | input | 1 | Memory interface takes the current grant |
| gnt | output | 13 | One-hot grant |
| ref_tmo | output | 4 | Sticky refresh timeout per chip |

## Verification
The assertions watch, on every cycle, the properties that hold at any instant:

- the grant is one-hot;
- a memory-manager command wins;
- a timed-out refresh wins over the queue;
- no blocked entry is granted;
- each counter moves by at most one;
- the timeout flag agrees with the count, both at the limit and at zero, and stays sticky in between.

The bench scenarios cover what depends on history or on ordering among levels. That includes the full ladder of levels, the lowest-index tie break, and the direction remembered from the last grant. It also includes the read/write alternation of the fallback, the cancelling of a simultaneous increment and decrement, and the timeout surviving the drain from six down to one.

// File: rtl/mem_cmd_arbiter.sv
module mem_cmd_arbiter #(
  parameter int N_ENT     = 8,
  parameter int N_CHIP    = 4,
  parameter int REF_LIMIT = 6,
  parameter int REF_MAX   = 15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mm_valid,
  input  logic [N_ENT-1:0]          ent_valid,
  input  logic [N_ENT-1:0]          ent_write,
  input  logic [N_ENT-1:0]          ent_hit,
  input  logic [N_ENT-1:0]          ent_tmin,
  input  logic [N_ENT-1:0]          ent_tmax,
  input  logic [N_ENT-1:0]          ent_prep,
  input  logic [N_ENT*N_ENT-1:0]    ent_dep,
  input  logic                      ref_inc,
  input  logic [$clog2(N_CHIP)-1:0] ref_inc_chip,
  input  logic                      gnt_ready,
  output logic [N_ENT+N_CHIP:0]     gnt,
  output logic [N_CHIP-1:0]         ref_tmo
);
  localparam int CHIP_W = $clog2(N_CHIP);
  localparam int CNT_W  = $clog2(REF_MAX + 1);

  logic [N_ENT-1:0]  elig, lv_same, lv_opp, rr_pref, ent_g;
  logic [N_CHIP-1:0] ref_pend, ref_g, tmo_nxt;
  logic [CNT_W-1:0]  cnt [N_CHIP];
  logic [CNT_W-1:0]  cnt_nxt [N_CHIP];
  logic              mm_g, fb_g, dir_last, rr_write;

  for (genvar i = 0; i < N_ENT; i++) begin : g_elig
    assign elig[i] = ent_valid[i] & ~|(ent_dep[i*N_ENT +: N_ENT] & ent_valid);
  end

  assign lv_same = elig & ent_hit & ~(ent_write ^ {N_ENT{dir_last}});
  assign lv_opp  = elig & ent_hit &  (ent_write ^ {N_ENT{dir_last}});
  assign rr_pref = elig & (rr_write ? ent_write : ~ent_write);

  always_comb begin
    mm_g  = 1'b0;
    fb_g  = 1'b0;
    ent_g = '0;
    ref_g = '0;
    if (mm_valid)                    mm_g  = 1'b1;
    else if (|(ref_tmo & ref_pend))  ref_g = (ref_tmo & ref_pend) & -(ref_tmo & ref_pend);
    else if (|(elig & ent_tmin))     ent_g = (elig & ent_tmin) & -(elig & ent_tmin);
    else if (|(elig & ent_tmax))     ent_g = (elig & ent_tmax) & -(elig & ent_tmax);
    else if (|lv_same)               ent_g = lv_same & -lv_same;
    else if (|lv_opp)                ent_g = lv_opp & -lv_opp;
    else if (|(elig & ent_prep))     ent_g = (elig & ent_prep) & -(elig & ent_prep);
    else if (|ref_pend)              ref_g = ref_pend & -ref_pend;
    else if (|elig) begin
      fb_g  = 1'b1;
      ent_g = |rr_pref ? (rr_pref & -rr_pref) : (elig & -elig);
    end
  end

  assign gnt = {ent_g, ref_g, mm_g};

  always_comb begin
    for (int c = 0; c < N_CHIP; c++) begin
      logic inc, dec;
      inc = ref_inc && (ref_inc_chip == CHIP_W'(c));
      dec = gnt_ready && ref_g[c];
      ref_pend[c] = (cnt[c] != '0);
      if (inc && !dec && cnt[c] != CNT_W'(REF_MAX)) cnt_nxt[c] = cnt[c] + 1'b1;
      else if (dec && !inc)                         cnt_nxt[c] = cnt[c] - 1'b1;
      else                                          cnt_nxt[c] = cnt[c];
      tmo_nxt[c] = (cnt_nxt[c] >= CNT_W'(REF_LIMIT)) || (ref_tmo[c] && cnt_nxt[c] != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_last <= 1'b0;
      rr_write <= 1'b0;
      ref_tmo  <= '0;
      for (int c = 0; c < N_CHIP; c++) cnt[c] <= '0;
    end else begin
      if (gnt_ready && |ent_g) dir_last <= |(ent_g & ent_write);
      if (gnt_ready && fb_g)   rr_write <= ~|(ent_g & ent_write);
      ref_tmo <= tmo_nxt;
      for (int c = 0; c < N_CHIP; c++) cnt[c] <= cnt_nxt[c];
    end
  end
endmodule

// File: rtl/mem_cmd_arbiter_chk.sv
module mem_cmd_arbiter_chk #(
  parameter int N_ENT = 8, N_CHIP = 4, REF_LIMIT = 6, CNT_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mm_valid,
  input logic [N_ENT-1:0]       ent_valid,
  input logic [N_ENT*N_ENT-1:0] ent_dep,
  input logic [N_ENT+N_CHIP:0]  gnt,
  input logic [N_CHIP-1:0]      ref_tmo,
  input logic [CNT_W-1:0]       cnt [N_CHIP]
);
  logic [N_ENT-1:0] blocked;
  for (genvar i = 0; i < N_ENT; i++) begin : g_blk
    assign blocked[i] = |(ent_dep[i*N_ENT +: N_ENT] & ent_valid);
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  a_r2_mm_first: assert property (@(posedge clk) disable iff (!rst_n) mm_valid |-> gnt[0]);
  a_r3_tmo_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!mm_valid && |ref_tmo) |-> |gnt[N_CHIP:1]);
  a_r9_dep_block: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[N_ENT+N_CHIP:N_CHIP+1] & blocked) == '0);

  for (genvar c = 0; c < N_CHIP; c++) begin : g_chip
    a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[c] == $past(cnt[c])) || (cnt[c] == $past(cnt[c]) + 1'b1) || (cnt[c] == $past(cnt[c]) - 1'b1));
    a_r11_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[c] >= CNT_W'(REF_LIMIT)) |-> ref_tmo[c]);
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[c] == '0) |-> !ref_tmo[c]);
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ref_tmo[c]) && cnt[c] != '0) |-> ref_tmo[c]);
  end
endmodule

bind mem_cmd_arbiter mem_cmd_arbiter_chk #(
  .N_ENT(N_ENT), .N_CHIP(N_CHIP), .REF_LIMIT(REF_LIMIT), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .mm_valid(mm_valid), .ent_valid(ent_valid),
  .ent_dep(ent_dep), .gnt(gnt), .ref_tmo(ref_tmo), .cnt(cnt)
);

// File: tb/mem_cmd_arbiter_tb_top.sv
module mem_cmd_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, mm_valid, ref_inc, gnt_ready;
  logic [7:0]  ent_valid, ent_write, ent_hit, ent_tmin, ent_tmax, ent_prep;
  logic [63:0] ent_dep;
  logic [1:0]  ref_inc_chip;
  logic [12:0] gnt;
  logic [3:0]  ref_tmo;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  mem_cmd_arbiter dut_i (.*);

  function automatic logic [12:0] ge(int i); return 13'(1) << (5 + i); endfunction
  function automatic logic [12:0] gr(int c); return 13'(1) << (1 + c); endfunction

  task automatic chk(string req, logic [12:0] act, logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr();
    mm_valid = 0; ent_valid = 0; ent_write = 0; ent_hit = 0; ent_tmin = 0;
    ent_tmax = 0; ent_prep = 0; ent_dep = 0; ref_inc = 0; ref_inc_chip = 0; gnt_ready = 0;
  endtask

  task automatic take();
    @(negedge clk); gnt_ready = 1;
    @(negedge clk); gnt_ready = 0; #1;
  endtask

  task automatic bump(int c);
    @(negedge clk); ref_inc = 1; ref_inc_chip = 2'(c);
    @(negedge clk); ref_inc = 0; #1;
  endtask

  task automatic t_reset();
    #1 chk("R1 idle grant", gnt, '0);
    chk("R11 reset tmo", 13'(ref_tmo), '0);
  endtask

  task automatic t_mm();
    ent_valid = 8'h01; ent_tmin = 8'h01; mm_valid = 1; #1;
    chk("R2 mm wins", gnt, 13'h1);
    clr(); #1;
  endtask

  task automatic t_levels();
    ent_valid = 8'h0F; ent_prep = 8'h01; ent_tmax = 8'h02; ent_tmin = 8'h04; ent_hit = 8'h08; #1;
    chk("R4 tmin first", gnt, ge(2));
    ent_valid = 8'h0B; #1 chk("R4 tmax next", gnt, ge(1));
    ent_valid = 8'h09; #1 chk("R4 hit next", gnt, ge(3));
    ent_valid = 8'h01; #1 chk("R6 prep", gnt, ge(0));
    clr(); ent_valid = 8'h28; ent_tmin = 8'h28; #1;
    chk("R8 low index tie", gnt, ge(3));
    clr(); #1;
  endtask

  task automatic t_dir();
    ent_valid = 8'h06; ent_hit = 8'h06; ent_write = 8'h02; #1;
    chk("R5 same dir read", gnt, ge(2));
    ent_valid = 8'h02; #1; take();
    ent_valid = 8'h06; #1;
    chk("R5 same dir write", gnt, ge(1));
    clr(); #1;
  endtask

  task automatic t_dep();
    ent_valid = 8'h11; ent_tmin = 8'h01; ent_dep[4] = 1'b1; #1;
    chk("R9 blocked", gnt, ge(4));
    ent_valid = 8'h01; #1 chk("R9 freed", gnt, ge(0));
    clr(); #1;
  endtask

  task automatic t_rr();
    ent_valid = 8'h44; ent_write = 8'h40; #1;
    chk("R7 read first", gnt, ge(2));
    take(); chk("R7 then write", gnt, ge(6));
    take(); chk("R7 back to read", gnt, ge(2));
    clr(); #1;
  endtask

  task automatic t_refresh();
    bump(1);
    chk("R10 pending refresh", gnt, gr(1));
    ent_valid = 8'h01; ent_prep = 8'h01; #1;
    chk("R6 prep over refresh", gnt, ge(0));
    clr();
    @(negedge clk); ref_inc = 1; ref_inc_chip = 1; gnt_ready = 1;
    @(negedge clk); clr(); #1;
    chk("R10 inc+dec cancel", gnt, gr(1));
    for (int k = 0; k < 5; k++) bump(2);
    chk("R11 below limit", 13'(ref_tmo), '0);
    bump(2);
    chk("R11 at limit", 13'(ref_tmo), 13'h4);
    ent_valid = 8'h01; ent_tmin = 8'h01; #1;
    chk("R3 tmo beats queue", gnt, gr(2));
    clr(); #1;
    take(); chk("R11 sticky at five", 13'(ref_tmo), 13'h4);
    for (int k = 0; k < 4; k++) take();
    chk("R11 sticky at one", 13'(ref_tmo), 13'h4);
    chk("R8 tmo chip over lower", gnt, gr(2));
    take(); chk("R11 cleared", 13'(ref_tmo), '0);
    chk("R10 other chip", gnt, gr(1));
    take(); chk("R1 drained", gnt, '0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    clr(); rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset(); t_mm(); t_levels(); t_dir(); t_dep(); t_rr(); t_refresh();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule